// File: doc/BRIEF.md
# Multi-Channel Temperature Limit Interrupt Controller

This block watches a stream of signed temperature samples tagged with a channel index and compares each one against a lower and an upper limit for that channel. Every channel has its own limit pair. The block keeps two kinds of per-channel flag:

- **Live violation flags** always reflect the most recent sample of the channel.
- **Sticky event flags** are set by a violating sample and stay set until software clears them.

Per-event mask bits, clear bits and a small enable field decide which events reach one active-high, level-sensitive interrupt line. The line falls by itself when the offending channel's temperature comes back inside its window.

Software reaches every setting through a word-addressed register port. Writes take effect at the next clock edge, and read data appears one cycle after the read request. The status, clear and mask words share one layout:

- Bit n (0 to 15) concerns channel n's lower limit.
- Bit 16+n concerns channel n's upper limit.

Top module: `thermal_limit_irq`

## Requirements
- R1: After reset, all limits read 0, the mask word (address 4) reads all ones, the enable word (address 0), the clear word (address 3), the sticky event word (address 2) and the live violation word (address 1) read 0, and `irq` is 0.
- R2: The limit word of channel n lives at word address 32+n. Its bits 11:0 hold the lower limit, bits 23:12 hold the upper limit and bits 31:24 read 0. A read returns data on `reg_rdata` one cycle after `reg_rd` is sampled.
- R3: A sample for channel n sets bit 16+n of the live violation word when it is greater than or equal to the upper limit, and sets bit n when it is less than or equal to the lower limit. Both comparisons treat the values as signed 12-bit numbers, and the sample leaves other channels' bits unchanged.
- R4: A later sample of the same channel that lies strictly inside its window clears that channel's live violation bits.
- R5: A violating sample sets the matching bit of the sticky event word. That bit stays set through later in-window samples.
- R6: While a bit of the clear word is 1, the matching event bit is 0 and violating samples do not set it. After the clear bit is written back to 0, the next violating sample sets the event bit again.
- R7: A mask bit of 1 keeps its event from `irq`; a mask bit of 0 lets it through.
- R8: The enable word holds 3 bits, which read back as written. Bit 0 enables lower-limit events, bit 1 enables upper-limit events, and bit 2, the critical enable, is stored but has no effect on `irq`.
- R9: `irq` is a register that is 1 exactly when, at the previous clock edge, some enabled, unmasked event bit was set while its live violation bit was also set. It therefore rises one cycle after the sample edge and falls without software action after an in-window sample.
- R10: Channel index and sample value are ignored while `smp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CHW (4) | Channel index of the sample |
| smp_temp | input | TW (12) | Signed sample value |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | ADDR_W (6) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| irq | output | 1 | Level-sensitive interrupt, active high |

## Verification
The bench builds the block with its default parameters: 16 channels, 12-bit limits and a 6-bit address. This puts the outer bit positions 15 and 31 of the shared status layout within reach, along with the last limit word at address 47. Limits that straddle zero and limits that are both negative exercise the signed comparison at the extremes -2048 and 2047. Samples equal to a limit check the inclusive boundaries.

// File: rtl/tli_pkg.sv
package tli_pkg;
  localparam int REG_W  = 32;
  localparam int HI_LSB = 16;
  localparam int EN_W   = 3;
  localparam int EN_LOW  = 0;
  localparam int EN_HIGH = 1;

  // word addresses of the control/status words
  localparam int ADR_EN       = 0;
  localparam int ADR_VIOL     = 1;
  localparam int ADR_EVENT    = 2;
  localparam int ADR_CLEAR    = 3;
  localparam int ADR_MASK     = 4;
  localparam int ADR_LIM_BASE = 32;
endpackage

// File: rtl/tli_limit_bank.sv
module tli_limit_bank #(
  parameter int NUM_CH = 16,
  parameter int TW     = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          wr_sel,
  input  logic [TW-1:0]              wr_lo,
  input  logic [TW-1:0]              wr_hi,
  output logic [NUM_CH-1:0][TW-1:0]  lo_lim,
  output logic [NUM_CH-1:0][TW-1:0]  hi_lim
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_lim[g] <= '0;
        hi_lim[g] <= '0;
      end else if (wr_sel[g]) begin
        lo_lim[g] <= wr_lo;
        hi_lim[g] <= wr_hi;
      end
    end
  end
endmodule

// File: rtl/tli_chan.sv
module tli_chan #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lo_lim,
  input  logic [TW-1:0] hi_lim,
  input  logic          clr_lo,
  input  logic          clr_hi,
  output logic          viol_lo,
  output logic          viol_hi,
  output logic          ev_lo,
  output logic          ev_hi
);
  logic below, above;

  always_comb begin
    below = $signed(temp) <= $signed(lo_lim);
    above = $signed(temp) >= $signed(hi_lim);
  end

  // live flags follow the latest sample of this channel
  always_ff @(posedge clk) begin
    if (rst) begin
      viol_lo <= 1'b0;
      viol_hi <= 1'b0;
    end else if (hit) begin
      viol_lo <= below;
      viol_hi <= above;
    end
  end

  // sticky event flags, held low while the clear bit is high
  always_ff @(posedge clk) begin
    if (rst)                 ev_lo <= 1'b0;
    else if (clr_lo)         ev_lo <= 1'b0;
    else if (hit && below)   ev_lo <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 ev_hi <= 1'b0;
    else if (clr_hi)         ev_hi <= 1'b0;
    else if (hit && above)   ev_hi <= 1'b1;
  end
endmodule

// File: rtl/tli_irq_merge.sv
module tli_irq_merge #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_lo,
  input  logic              en_hi,
  input  logic [NUM_CH-1:0] ev_lo,
  input  logic [NUM_CH-1:0] ev_hi,
  input  logic [NUM_CH-1:0] viol_lo,
  input  logic [NUM_CH-1:0] viol_hi,
  input  logic [NUM_CH-1:0] mask_lo,
  input  logic [NUM_CH-1:0] mask_hi,
  output logic              irq
);
  logic any_lo, any_hi;

  always_comb begin
    any_lo = en_lo && |(ev_lo & viol_lo & ~mask_lo);
    any_hi = en_hi && |(ev_hi & viol_hi & ~mask_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any_lo || any_hi;
  end
endmodule

// File: rtl/thermal_limit_irq.sv
module thermal_limit_irq
  import tli_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TW     = 12,
  parameter int ADDR_W = 6,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [CHW-1:0]    smp_chan,
  input  logic [TW-1:0]     smp_temp,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(ADR_EN);
  localparam logic [ADDR_W-1:0] A_VIOL  = ADDR_W'(ADR_VIOL);
  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(ADR_EVENT);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(ADR_CLEAR);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADR_MASK);

  function automatic logic [REG_W-1:0] join_halves(input logic [NUM_CH-1:0] lo,
                                                   input logic [NUM_CH-1:0] hi);
    logic [REG_W-1:0] w;
    w = '0;
    w[NUM_CH-1:0]       = lo;
    w[HI_LSB +: NUM_CH] = hi;
    return w;
  endfunction

  logic [EN_W-1:0]   en_q;
  logic [NUM_CH-1:0] clr_lo_q, clr_hi_q, mask_lo_q, mask_hi_q;
  logic [NUM_CH-1:0] viol_lo, viol_hi, ev_lo, ev_hi;
  logic [NUM_CH-1:0] lim_sel, lim_we, hit;
  logic [NUM_CH-1:0][TW-1:0] lo_lim, hi_lim;
  logic [REG_W-1:0]  viol_w, event_w, clr_w, mask_w, rd_mux;

  // one-hot decode of the limit words and of the sample channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign lim_sel[g] = (reg_addr == ADDR_W'(ADR_LIM_BASE + g));
    assign hit[g]     = smp_valid && (smp_chan == CHW'(g));
  end
  assign lim_we = lim_sel & {NUM_CH{reg_wr}};

  // control words
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      clr_lo_q  <= '0;
      clr_hi_q  <= '0;
      mask_lo_q <= '1;
      mask_hi_q <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN: en_q <= reg_wdata[EN_W-1:0];
        A_CLEAR: begin
          clr_lo_q <= reg_wdata[NUM_CH-1:0];
          clr_hi_q <= reg_wdata[HI_LSB +: NUM_CH];
        end
        A_MASK: begin
          mask_lo_q <= reg_wdata[NUM_CH-1:0];
          mask_hi_q <= reg_wdata[HI_LSB +: NUM_CH];
        end
        default: ;
      endcase
    end
  end

  tli_limit_bank #(.NUM_CH(NUM_CH), .TW(TW)) i_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (lim_we),
    .wr_lo  (reg_wdata[TW-1:0]),
    .wr_hi  (reg_wdata[2*TW-1:TW]),
    .lo_lim (lo_lim),
    .hi_lim (hi_lim)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tli_chan #(.TW(TW)) i_chan (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[g]),
      .temp    (smp_temp),
      .lo_lim  (lo_lim[g]),
      .hi_lim  (hi_lim[g]),
      .clr_lo  (clr_lo_q[g]),
      .clr_hi  (clr_hi_q[g]),
      .viol_lo (viol_lo[g]),
      .viol_hi (viol_hi[g]),
      .ev_lo   (ev_lo[g]),
      .ev_hi   (ev_hi[g])
    );
  end

  tli_irq_merge #(.NUM_CH(NUM_CH)) i_merge (
    .clk     (clk),
    .rst     (rst),
    .en_lo   (en_q[EN_LOW]),
    .en_hi   (en_q[EN_HIGH]),
    .ev_lo   (ev_lo),
    .ev_hi   (ev_hi),
    .viol_lo (viol_lo),
    .viol_hi (viol_hi),
    .mask_lo (mask_lo_q),
    .mask_hi (mask_hi_q),
    .irq     (irq)
  );

  assign viol_w  = join_halves(viol_lo, viol_hi);
  assign event_w = join_halves(ev_lo, ev_hi);
  assign clr_w   = join_halves(clr_lo_q, clr_hi_q);
  assign mask_w  = join_halves(mask_lo_q, mask_hi_q);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_EN:    rd_mux = REG_W'(en_q);
      A_VIOL:  rd_mux = viol_w;
      A_EVENT: rd_mux = event_w;
      A_CLEAR: rd_mux = clr_w;
      A_MASK:  rd_mux = mask_w;
      default: begin
        for (int n = 0; n < NUM_CH; n++)
          if (lim_sel[n]) rd_mux = REG_W'({hi_lim[n], lo_lim[n]});
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/tli_checker.sv
module tli_checker (
  input logic        clk,
  input logic        rst,
  input logic        smp_valid,
  input logic        irq,
  input logic [1:0]  en_lu,
  input logic [31:0] viol,
  input logic [31:0] evt,
  input logic [31:0] clr,
  input logic [31:0] mask
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en_lu != 2'b00)); // R8

  AST_VIOL_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(viol)); // R10

  AST_EVENT_SET_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ((evt & ~$past(evt)) == 32'h0)); // R5

  AST_EVENT_FALL_BY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(evt) & ~evt & ~$past(clr)) == 32'h0)); // R6

  AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (clr != 32'h0) |=> ((evt & $past(clr)) == 32'h0)); // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((evt & viol & ~mask) != 32'h0)); // R9

  AST_IRQ_FALLS_ALONE: assert property (@(posedge clk) disable iff (rst)
    ((evt & viol & ~mask) == 32'h0) |=> !irq); // R7
endmodule

bind thermal_limit_irq tli_checker i_tli_checker (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .irq       (irq),
  .en_lu     (en_q[1:0]),
  .viol      (viol_w),
  .evt       (event_w),
  .clr       (clr_w),
  .mask      (mask_w)
);

// File: tb/test_thermal_limit_irq.sv
`timescale 1ns/1ps
module test_thermal_limit_irq;
  localparam int NUM_CH = 16;
  localparam int TW     = 12;
  localparam int ADDR_W = 6;
  localparam int CHW    = 4;

  localparam logic [5:0] A_EN = 6'd0, A_VIOL = 6'd1, A_EVENT = 6'd2,
                         A_CLEAR = 6'd3, A_MASK = 6'd4, A_LIM0 = 6'd32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              smp_valid = 1'b0;
  logic [CHW-1:0]    smp_chan = '0;
  logic [TW-1:0]     smp_temp = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq;

  thermal_limit_irq #(.NUM_CH(NUM_CH), .TW(TW), .ADDR_W(ADDR_W)) i_thermal_limit_irq (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_temp(smp_temp), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  logic  rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: compares read data one cycle after each read request
  always @(negedge clk) begin
    item_t it;
    if (rd_seen === 1'b1) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %h expected none", reg_rdata);
      end else begin
        it = sb_q.pop_front();
        if (reg_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic smp(int ch, int t);
    smp_valid = 1'b1; smp_chan = CHW'(ch); smp_temp = TW'(t);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic chk_irq(logic e, string tag);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  function automatic logic [31:0] limw(int lo, int hi);
    return {8'h00, 12'(hi), 12'(lo)};
  endfunction

  function automatic logic [31:0] bit_lo(int ch);
    return 32'h1 << ch;
  endfunction

  function automatic logic [31:0] bit_hi(int ch);
    return 32'h1 << (16 + ch);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_EN,    32'h0,        "R1 enable after reset");
    rd(A_MASK,  32'hFFFF_FFFF,"R1 mask after reset");
    rd(A_EVENT, 32'h0,        "R1 events after reset");
    rd(A_VIOL,  32'h0,        "R1 violations after reset");
    rd(A_CLEAR, 32'h0,        "R1 clear after reset");
    rd(A_LIM0 + 6'd5, 32'h0,  "R1 limit word after reset");

    // R2 limit layout and read-back
    wr(A_LIM0 + 6'd3, 32'hFF00_0000 | limw(-20, 100));
    rd(A_LIM0 + 6'd3, limw(-20, 100), "R2 limit word ch3, top byte zero");

    wr(A_EN, 32'h3);
    wr(A_MASK, ~(bit_lo(3) | bit_hi(3)));

    // R3 in-window sample
    smp(3, 50);
    rd(A_VIOL, 32'h0, "R3 in-window sample ch3");
    chk_irq(1'b0, "R9 no irq in window");

    // R3 upper boundary, R9 timing
    smp(3, 100);
    chk_irq(1'b0, "R9 irq not yet high at sample edge");
    idle(1);
    chk_irq(1'b1, "R9 irq high one cycle after sample");
    rd(A_VIOL,  bit_hi(3), "R3 upper equal violates");
    rd(A_EVENT, bit_hi(3), "R5 upper event set");

    // R4 / R5 / R9 back in window
    smp(3, 60);
    idle(1);
    chk_irq(1'b0, "R9 irq falls without software");
    rd(A_VIOL,  32'h0,     "R4 live flag cleared by in-window sample");
    rd(A_EVENT, bit_hi(3), "R5 event stays sticky");

    // R3 lower boundary
    smp(3, -20);
    rd(A_VIOL,  bit_lo(3), "R3 lower equal violates");
    rd(A_EVENT, bit_lo(3) | bit_hi(3), "R5 lower event set");
    chk_irq(1'b1, "R9 irq from lower event");

    // R6 clear handshake
    wr(A_CLEAR, bit_lo(3));
    idle(2);
    chk_irq(1'b0, "R6 irq drops while cleared");
    rd(A_EVENT, bit_hi(3), "R6 clear held zeroes event");
    smp(3, -30);
    rd(A_EVENT, bit_hi(3), "R6 violating sample ignored while clear high");
    rd(A_CLEAR, bit_lo(3), "R6 clear word reads back");
    wr(A_CLEAR, 32'h0);
    rd(A_EVENT, bit_hi(3), "R6 no re-set without new sample");
    smp(3, -25);
    rd(A_EVENT, bit_lo(3) | bit_hi(3), "R6 event re-set after clear released");
    chk_irq(1'b1, "R6 irq back after re-set");

    // R7 mask
    wr(A_MASK, 32'hFFFF_FFFF);
    idle(1);
    chk_irq(1'b0, "R7 mask blocks event");
    wr(A_MASK, ~bit_lo(3));
    idle(1);
    chk_irq(1'b1, "R7 cleared mask passes event");

    // R8 enables
    wr(A_EN, 32'h4);
    idle(1);
    chk_irq(1'b0, "R8 critical enable alone has no effect");
    rd(A_EN, 32'h4, "R8 enable reads back");
    wr(A_EN, 32'h2);
    idle(1);
    chk_irq(1'b0, "R8 upper enable does not pass lower event");
    wr(A_EN, 32'h1);
    idle(1);
    chk_irq(1'b1, "R8 lower enable passes lower event");

    // R10 strobe low ignored
    smp_chan = CHW'(3); smp_temp = TW'(50);
    idle(2);
    rd(A_VIOL, bit_lo(3), "R10 sample without strobe ignored");
    chk_irq(1'b1, "R10 irq unchanged without strobe");

    // R3 signed comparison with negative window on ch7
    wr(A_LIM0 + 6'd7, limw(-100, -10));
    rd(A_LIM0 + 6'd7, limw(-100, -10), "R2 negative limits ch7");
    smp(7, -50);
    rd(A_VIOL, bit_lo(3), "R3 signed in-window ch7, other channels kept");
    smp(7, -5);
    rd(A_VIOL, bit_lo(3) | bit_hi(7), "R3 signed upper ch7");
    smp(7, -101);
    rd(A_VIOL, bit_lo(3) | bit_lo(7), "R4 ch7 upper flag replaced by lower");
    rd(A_EVENT, bit_lo(3) | bit_hi(3) | bit_lo(7) | bit_hi(7), "R5 events ch3 and ch7");

    // R3 last channel at value extremes, zero limits
    smp(15, 2047);
    rd(A_VIOL, bit_lo(3) | bit_lo(7) | bit_hi(15), "R3 ch15 max value upper");
    smp(15, -2048);
    rd(A_VIOL, bit_lo(3) | bit_lo(7) | bit_lo(15), "R3 ch15 min value lower");

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule